// File: doc/BRIEF.md
# Infrared Remote Carrier Generator

This block makes the modulation carrier for an infrared remote-control transmitter. It runs from a 455 kHz system clock and drives a single carrier output pin. A build-time parameter chooses the carrier source. In divider mode a small state machine divides the clock into one of three preset carriers: 38 kHz with a one-third mark, 38 kHz with a half mark, or 57 kHz with a half mark. In timer mode the output changes level each time an 8-bit up-counter overflows, and the counter then restarts from a programmable reload value. This covers carriers from about 1 kHz to about 200 kHz.

Software drives the block through a plain write port with three registers: an enable bit (address 0, data bit 0), a 2-bit carrier select (address 1, data bits 1:0) and the reload value (address 2, data bits 7:0). The state machine has three states. ST_OFF holds the output low and clears the count. ST_MARK drives the output high. ST_SPACE drives it low. The transitions are: OFF to MARK on enable (divider mode), OFF to SPACE on enable (timer mode), MARK to SPACE when the mark length has elapsed or the counter overflows, SPACE to MARK at the end of the period or on overflow, and any state to OFF when the enable bit clears. The select code takes effect only when the state machine enters ST_MARK, so a period that has started always finishes with the settings it started with.

Top module: `ir_carrier_gen`

## Requirements
- R1: After reset the output is low, the enable bit is clear, the reload value is zero and the select code is 00. Enabling without first writing a select gives 38 kHz at one-third duty.
- R2: While the enable bit is clear the output stays low, including when the select or reload registers are written.
- R3: Select 00 gives a period of 12 clocks, high for 4 and low for 8.
- R4: Select 01 gives a period of 12 clocks, high for 6 and low for 6.
- R5: Select 10 gives a period of 8 clocks, high for 4 and low for 4.
- R6: In divider mode, a write that sets the enable bit at clock edge N makes the output high after edge N+1, and that first mark has its full length.
- R7: A change of select while a period is running does not alter that period. The new setting applies from the next mark onward.
- R8: A write that clears the enable bit at edge N makes the output low after edge N+1. A later enable starts a fresh, complete period.
- R9: Select 11 is reserved and behaves the same as select 00.
- R10: In timer mode the output is low after enabling and then toggles every 256 minus reload clocks. High time and low time are equal.
- R11: In timer mode a new reload value is used from the next overflow onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 455 kHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 enable, 1 carrier select, 2 reload |
| wr_data | input | 8 | Write data |
| carrier_out | output | 1 | Carrier output pin |

## Verification
The assertions assume that every write is a single-cycle strobe. They also assume that the enable register is the only thing that starts or stops the carrier, so after each transition they can bound the mark and space run lengths by the longest preset. The stimulus writes only through the register port, one cycle per strobe, and uses legal register addresses. Random select codes include the reserved value. Random reload values stay in the upper range so that each measured half period stays short.

// File: rtl/ir_carrier_pkg.sv
package ir_carrier_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_MARK  = 2'd1,
        ST_SPACE = 2'd2
    } car_state_e;

    typedef enum logic [1:0] {
        SEL_38_THIRD = 2'b00,
        SEL_38_HALF  = 2'b01,
        SEL_57_HALF  = 2'b10,
        SEL_RSVD     = 2'b11
    } car_sel_e;

    localparam logic [1:0] ADDR_ENABLE = 2'd0;
    localparam logic [1:0] ADDR_SELECT = 2'd1;
    localparam logic [1:0] ADDR_RELOAD = 2'd2;

endpackage

// File: rtl/ir_carrier_regs.sv
module ir_carrier_regs
    import ir_carrier_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int TMR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              en_q,
    output car_sel_e          sel_q,
    output logic [TMR_W-1:0]  reload_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            sel_q    <= SEL_38_THIRD;
            reload_q <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_ENABLE: en_q     <= wr_data[0];
                ADDR_SELECT: sel_q    <= car_sel_e'(wr_data[1:0]);
                ADDR_RELOAD: reload_q <= wr_data[TMR_W-1:0];
                default:     ;
            endcase
        end
    end

endmodule

// File: rtl/ir_carrier_fixed.sv
module ir_carrier_fixed
    import ir_carrier_pkg::*;
#(
    parameter int PER_38      = 12,
    parameter int HI_38_THIRD = 4,
    parameter int HI_38_HALF  = 6,
    parameter int PER_57      = 8,
    parameter int HI_57       = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  car_sel_e sel,
    output logic     carrier
);

    localparam int MAX_PER = (PER_38 > PER_57) ? PER_38 : PER_57;
    localparam int CNT_W   = $clog2(MAX_PER + 1);

    car_state_e       state_q, state_d;
    car_sel_e         act_q, act_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] mark_len, per_len;

    // Lengths for the setting latched at the start of the current period.
    always_comb begin
        unique case (act_q)
            SEL_38_HALF: begin
                mark_len = CNT_W'(HI_38_HALF);
                per_len  = CNT_W'(PER_38);
            end
            SEL_57_HALF: begin
                mark_len = CNT_W'(HI_57);
                per_len  = CNT_W'(PER_57);
            end
            default: begin
                mark_len = CNT_W'(HI_38_THIRD);
                per_len  = CNT_W'(PER_38);
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
            act_q   <= SEL_38_THIRD;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            act_q   <= act_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + 1'b1;
        act_d   = act_q;
        unique case (state_q)
            ST_OFF: begin
                cnt_d = '0;
                if (en) begin
                    state_d = ST_MARK;
                    act_d   = sel;
                end
            end
            ST_MARK: begin
                if (!en) begin
                    state_d = ST_OFF;
                    cnt_d   = '0;
                end else if (cnt_q == mark_len - 1'b1) begin
                    state_d = ST_SPACE;
                end
            end
            ST_SPACE: begin
                if (!en) begin
                    state_d = ST_OFF;
                    cnt_d   = '0;
                end else if (cnt_q == per_len - 1'b1) begin
                    state_d = ST_MARK;
                    cnt_d   = '0;
                    act_d   = sel;
                end
            end
            default: begin
                state_d = ST_OFF;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        carrier = (state_q == ST_MARK);
    end

endmodule

// File: rtl/ir_carrier_timer.sv
module ir_carrier_timer
    import ir_carrier_pkg::*;
#(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [TMR_W-1:0] reload,
    output logic             carrier
);

    car_state_e       state_q, state_d;
    logic [TMR_W-1:0] cnt_q, cnt_d;
    logic             ovf;

    always_comb ovf = (cnt_q == {TMR_W{1'b1}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + 1'b1;
        unique case (state_q)
            ST_OFF: begin
                cnt_d = reload;
                if (en) state_d = ST_SPACE;
            end
            ST_SPACE: begin
                if (!en) begin
                    state_d = ST_OFF;
                    cnt_d   = reload;
                end else if (ovf) begin
                    state_d = ST_MARK;
                    cnt_d   = reload;
                end
            end
            ST_MARK: begin
                if (!en) begin
                    state_d = ST_OFF;
                    cnt_d   = reload;
                end else if (ovf) begin
                    state_d = ST_SPACE;
                    cnt_d   = reload;
                end
            end
            default: begin
                state_d = ST_OFF;
                cnt_d   = reload;
            end
        endcase
    end

    always_comb begin
        carrier = (state_q == ST_MARK);
    end

endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen
    import ir_carrier_pkg::*;
#(
    parameter bit USE_TIMER   = 1'b0,
    parameter int DATA_W      = 8,
    parameter int TMR_W       = 8,
    parameter int PER_38      = 12,
    parameter int HI_38_THIRD = 4,
    parameter int HI_38_HALF  = 6,
    parameter int PER_57      = 8,
    parameter int HI_57       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              carrier_out
);

    logic             en_q;
    car_sel_e         sel_q;
    logic [TMR_W-1:0] reload_q;

    ir_carrier_regs #(
        .DATA_W (DATA_W),
        .TMR_W  (TMR_W)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .en_q     (en_q),
        .sel_q    (sel_q),
        .reload_q (reload_q)
    );

    generate
        if (USE_TIMER) begin : g_timer
            logic unused_sel;
            assign unused_sel = ^sel_q;
            ir_carrier_timer #(
                .TMR_W (TMR_W)
            ) src_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .en      (en_q),
                .reload  (reload_q),
                .carrier (carrier_out)
            );
        end else begin : g_fixed
            logic unused_reload;
            assign unused_reload = ^reload_q;
            ir_carrier_fixed #(
                .PER_38      (PER_38),
                .HI_38_THIRD (HI_38_THIRD),
                .HI_38_HALF  (HI_38_HALF),
                .PER_57      (PER_57),
                .HI_57       (HI_57)
            ) src_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .en      (en_q),
                .sel     (sel_q),
                .carrier (carrier_out)
            );
        end
    endgenerate

endmodule

// File: rtl/ir_carrier_chk.sv
module ir_carrier_chk #(
    parameter bit USE_TIMER = 1'b0,
    parameter int MAX_MARK  = 6,
    parameter int MAX_SPACE = 8
) (
    input logic clk,
    input logic rst_n,
    input logic en_q,
    input logic carrier_out
);

    logic [7:0] hi_run_q, lo_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run_q <= '0;
            lo_run_q <= '0;
        end else begin
            hi_run_q <= carrier_out ? ((hi_run_q == 8'hFF) ? hi_run_q : hi_run_q + 8'd1) : 8'd0;
            lo_run_q <= (en_q && !carrier_out) ? ((lo_run_q == 8'hFF) ? lo_run_q : lo_run_q + 8'd1) : 8'd0;
        end
    end

    // R2: a cleared enable forces the pin low on the next cycle
    p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> !carrier_out);

    generate
        if (USE_TIMER) begin : g_tmr_chk
            // R10: timer carrier starts in the low phase
            p_tmr_first_space_r10: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(en_q) |=> !carrier_out);
        end else begin : g_fix_chk
            // R6: divider carrier starts with a mark
            p_first_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(en_q) |=> carrier_out);
            // R4: no mark is longer than the longest preset mark
            p_mark_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
                carrier_out |-> (hi_run_q < 8'(MAX_MARK)));
            // R3: no enabled space is longer than the longest preset space
            p_space_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (en_q && !carrier_out) |-> (lo_run_q < 8'(MAX_SPACE)));
        end
    endgenerate

endmodule

bind ir_carrier_gen ir_carrier_chk #(
    .USE_TIMER (USE_TIMER),
    .MAX_MARK  (HI_38_HALF),
    .MAX_SPACE (PER_38 - HI_38_THIRD)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_q        (en_q),
    .carrier_out (carrier_out)
);

// File: tb/ir_carrier_gen_tb_top.sv
module ir_carrier_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en_f = 1'b0, wr_en_t = 1'b0;
    logic [1:0] wr_addr_f = '0, wr_addr_t = '0;
    logic [7:0] wr_data_f = '0, wr_data_t = '0;
    logic       car_f, car_t;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    ir_carrier_gen #(.USE_TIMER(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_f), .wr_addr(wr_addr_f),
        .wr_data(wr_data_f), .carrier_out(car_f)
    );

    ir_carrier_gen #(.USE_TIMER(1'b1)) dut_t_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_t), .wr_addr(wr_addr_t),
        .wr_data(wr_data_t), .carrier_out(car_t)
    );

    function automatic int exp_hi(input logic [1:0] s);
        return (s == 2'b01) ? 6 : 4;
    endfunction

    function automatic int exp_lo(input logic [1:0] s);
        return (s == 2'b01) ? 6 : ((s == 2'b10) ? 4 : 8);
    endfunction

    function automatic logic pin(input bit t);
        return t ? car_t : car_f;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input bit t, input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        if (t) begin wr_en_t = 1'b1; wr_addr_t = a; wr_data_t = d; end
        else   begin wr_en_f = 1'b1; wr_addr_f = a; wr_data_f = d; end
        @(negedge clk);
        wr_en_t = 1'b0;
        wr_en_f = 1'b0;
    endtask

    // Count cycles while the pin equals lvl (sampled at negedges).
    task automatic run_len(input bit t, input logic lvl, output int n);
        n = 0;
        while (pin(t) == lvl && n < 2000) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Align to a rising edge, then measure one full mark and space.
    task automatic measure(input bit t, output int hi, output int lo);
        int skip;
        run_len(t, 1'b1, skip);
        run_len(t, 1'b0, skip);
        run_len(t, 1'b1, hi);
        run_len(t, 1'b0, lo);
    endtask

    initial begin
        int hi, lo, n, ones;
        void'($urandom(32'd4144));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 reset pin fixed", int'(car_f), 0);
        check("R1 reset pin timer", int'(car_t), 0);

        // R6 / R1: enable with default select
        wr(0, 2'd0, 8'h01);
        check("R6 pin still low one edge after write", int'(car_f), 0);
        @(negedge clk);
        check("R6 pin high two edges after write", int'(car_f), 1);
        run_len(0, 1'b1, n);
        check("R6 first mark full length", n, 4);
        run_len(0, 1'b0, n);
        check("R1 default select space", n, 8);
        measure(0, hi, lo);
        check("R3 mark", hi, 4);
        check("R3 space", lo, 8);

        // R8: disable
        wr(0, 2'd0, 8'h00);
        @(negedge clk);
        check("R8 low after disable", int'(car_f), 0);
        // R2: writes while disabled do not move the pin
        ones = 0;
        wr(0, 2'd1, 8'h01);
        repeat (20) begin @(negedge clk); ones += int'(car_f); end
        check("R2 idle while disabled", ones, 0);

        // R8 re-enable gives a fresh full period (select now 01)
        wr(0, 2'd0, 8'h01);
        @(negedge clk);
        run_len(0, 1'b1, n);
        check("R8 fresh mark after re-enable", n, 6);
        run_len(0, 1'b0, n);
        check("R4 space", n, 6);
        measure(0, hi, lo);
        check("R4 mark", hi, 6);

        // R5
        wr(0, 2'd1, 8'h02);
        measure(0, hi, lo);
        measure(0, hi, lo);
        check("R5 mark", hi, 4);
        check("R5 space", lo, 4);

        // R9: reserved code
        wr(0, 2'd1, 8'h03);
        measure(0, hi, lo);
        measure(0, hi, lo);
        check("R9 mark", hi, 4);
        check("R9 space", lo, 8);

        // R7: change select in the middle of a mark (current code 11 -> 10)
        run_len(0, 1'b1, n);
        run_len(0, 1'b0, n);
        wr(0, 2'd1, 8'h02);
        run_len(0, 1'b1, n);
        run_len(0, 1'b0, n);
        check("R7 running period keeps old space", n, 8);
        run_len(0, 1'b1, hi);
        run_len(0, 1'b0, lo);
        check("R7 new mark after boundary", hi, 4);
        check("R7 new space after boundary", lo, 4);

        // Random select codes
        for (int i = 0; i < 24; i++) begin
            logic [1:0] s;
            s = 2'($urandom_range(0, 3));
            wr(0, 2'd1, {6'd0, s});
            if ($urandom_range(0, 3) == 0) begin
                wr(0, 2'd0, 8'h00);
                @(negedge clk);
                check("R8 random disable", int'(car_f), 0);
                wr(0, 2'd0, 8'h01);
                @(negedge clk);
                check("R6 random enable", int'(car_f), 1);
            end
            measure(0, hi, lo);
            measure(0, hi, lo);
            check("R3 R4 R5 R9 random mark", hi, exp_hi(s));
            check("R3 R4 R5 R9 random space", lo, exp_lo(s));
        end

        // R10: timer mode
        wr(1, 2'd2, 8'hF0);
        wr(1, 2'd0, 8'h01);
        @(negedge clk);
        check("R10 low after enable", int'(car_t), 0);
        run_len(1, 1'b0, n);
        check("R10 first space", n, 16);
        run_len(1, 1'b1, n);
        check("R10 first mark", n, 16);
        measure(1, hi, lo);
        check("R10 mark", hi, 16);
        check("R10 space", lo, 16);

        // R11: new reload from next overflow
        wr(1, 2'd2, 8'hF8);
        measure(1, hi, lo);
        measure(1, hi, lo);
        check("R11 mark", hi, 8);
        check("R11 space", lo, 8);

        for (int i = 0; i < 10; i++) begin
            logic [7:0] r;
            r = 8'($urandom_range(8'hC0, 8'hFE));
            wr(1, 2'd2, r);
            measure(1, hi, lo);
            measure(1, hi, lo);
            check("R10 R11 random mark", hi, 256 - int'(r));
            check("R10 R11 random space", lo, 256 - int'(r));
        end

        wr(1, 2'd0, 8'h00);
        ones = 0;
        repeat (40) begin @(negedge clk); ones += int'(car_t); end
        check("R2 timer idle", ones, 0);

        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule